// File: doc/BRIEF.md
# Video Timing Control Conditioner

This block sits in the pixel clock domain ahead of a serial link framer and conditions the three video timing strobes: line sync, frame sync and the active-pixel enable. When its filter is on, the line sync and enable inputs must hold a level for a minimum number of clocks before that level reaches the output. Shorter pulses are discarded and the output keeps its previous level. A pulse that is accepted comes out with its original width. Frame sync is never deglitched. All three outputs carry the same fixed latency in every mode, so the strobes stay aligned with each other.

Each output is also watched for its transition rate over a sliding window of pixel clocks. Line sync and enable may toggle at most twice in any window. Frame sync may toggle only once. A toggle that breaks the cap sets a sticky per-signal flag. Software clears the flag with a one-cycle clear strobe. The filter mode is held in a one-bit configuration register that is loaded by a write strobe.

Per channel, a small state machine moves from FILL (collecting the first samples after reset) to SEEK (waiting for the first run of equal samples) to RUN (normal conditioning). The rate monitor has two states: CLEAN goes to TRIPPED when a toggle breaks the cap, and TRIPPED returns to CLEAN when a clear strobe arrives in a cycle with no new violation.

Top module: `vidctl_pulse_filter`

## Requirements
- R1: While reset is asserted and in the first cycles after it, all three outputs are low and all three flags are clear. The filter mode register resets to enabled.
- R2: With the filter enabled, a line sync or enable pulse narrower than 3 clocks never reaches the output, and the output keeps its previous level.
- R3: With the filter enabled, a line sync or enable level held for at least 3 clocks appears at the output 3 clocks after the edge that first samples it, with the same width.
- R4: With the filter disabled, line sync and enable are passed through after 3 clocks, including 1-clock pulses.
- R5: Frame sync is never deglitched. A 1-clock frame pulse passes in either mode, with the same 3-clock latency.
- R6: After reset, every output stays low until its input has shown 3 equal consecutive samples. The output then takes that level.
- R7: viol_flag bit 0 (line sync) and bit 2 (enable) are set one clock after an output toggle that lies fewer than 130 clocks after the toggle two before it. A spacing of exactly 130 clocks does not set the flag.
- R8: viol_flag bit 1 (frame sync) is set one clock after a frame output toggle that lies fewer than 130 clocks after the previous frame toggle. A spacing of 130 does not set the flag.
- R9: Flags are sticky. A viol_clr bit that is high at a clock edge clears the matching flag, unless a new violation on that channel is recorded at the same edge, in which case the flag stays set.
- R10: When cfg_wr is high at a clock edge, cfg_filt_en is loaded into the mode register (1 = filter, 0 = bypass). The new mode governs the decisions from the next edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the mode register |
| cfg_filt_en | input | 1 | Mode value: 1 = filter, 0 = bypass |
| hs_in | input | 1 | Raw line sync |
| vs_in | input | 1 | Raw frame sync |
| de_in | input | 1 | Raw data enable |
| viol_clr | input | 3 | Per-channel flag clear (bit 0 line, 1 frame, 2 enable) |
| hs_out | output | 1 | Conditioned line sync |
| vs_out | output | 1 | Conditioned frame sync |
| de_out | output | 1 | Conditioned data enable |
| viol_flag | output | 3 | Sticky rate-violation flags (bit 0 line, 1 frame, 2 enable) |

## Verification
A rate violation being recorded and a clear strobe for the same channel can meet at one clock edge. The bench provokes this on the enable channel. It drives a third enable toggle shortly after two earlier ones and counts the registers on the path: 3 to the output, plus 1 for the flag. It then raises the clear strobe for exactly that edge. The outcome is judged both by the behavioural model, compared on every clock, and by a directed check that expects the flag still set. A follow-up clear in a quiet cycle must then drop the flag.

// File: rtl/vcf_pkg.sv
package vcf_pkg;

    localparam int CH_HS  = 0;
    localparam int CH_VS  = 1;
    localparam int CH_DE  = 2;
    localparam int NUM_CH = 3;

    // per-channel conditioner phases
    typedef enum logic [1:0] {
        DG_FILL = 2'd0,
        DG_SEEK = 2'd1,
        DG_RUN  = 2'd2
    } dg_state_e;

    // per-channel rate monitor phases
    typedef enum logic {
        RM_CLEAN   = 1'b0,
        RM_TRIPPED = 1'b1
    } rm_state_e;

endpackage

// File: rtl/vcf_deglitch.sv
module vcf_deglitch
    import vcf_pkg::*;
#(
    parameter int MIN_W    = 3,
    parameter bit DEGLITCH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic raw_in,
    output logic sig_out
);

    localparam int CNT_W = (MIN_W > 1) ? $clog2(MIN_W) : 1;
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(MIN_W - 1);

    // smp_q[0] is the newest sample, smp_q[MIN_W-1] the oldest
    logic [MIN_W-1:0] smp_q;
    logic             steady;
    logic             newest;
    logic             oldest;

    dg_state_e        state_q, state_d;
    logic [CNT_W-1:0] fill_q, fill_d;
    logic             out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= {smp_q[MIN_W-2:0], raw_in};
        end
    end

    assign steady = (&smp_q) | ~(|smp_q);
    assign newest = smp_q[0];
    assign oldest = smp_q[MIN_W-1];

    // next-state logic
    always_comb begin
        state_d = state_q;
        fill_d  = fill_q;
        unique case (state_q)
            DG_FILL: begin
                if (fill_q == FILL_LAST) begin
                    state_d = DG_SEEK;
                    fill_d  = '0;
                end else begin
                    fill_d  = fill_q + 1'b1;
                end
            end
            DG_SEEK: begin
                if (steady) begin
                    state_d = DG_RUN;
                end
            end
            DG_RUN: begin
                state_d = DG_RUN;
            end
            default: begin
                state_d = DG_FILL;
                fill_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DG_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            unique case (state_q)
                DG_FILL: out_q <= 1'b0;
                DG_SEEK: begin
                    if (steady) begin
                        out_q <= newest;
                    end
                end
                DG_RUN: begin
                    if (DEGLITCH && filt_en) begin
                        if (steady) begin
                            out_q <= newest;
                        end
                    end else begin
                        out_q <= oldest;
                    end
                end
                default: out_q <= 1'b0;
            endcase
        end
    end

    assign sig_out = out_q;

endmodule

// File: rtl/vcf_rate_mon.sv
module vcf_rate_mon
    import vcf_pkg::*;
#(
    parameter int WIN   = 130,
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic clr,
    output logic flag
);

    localparam int AGE_W = $clog2(WIN + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WIN);

    logic             sig_q;
    logic             toggled;
    logic             too_fast;
    // ages_q[j]: clocks since the (j+1)-th most recent earlier toggle
    logic [AGE_W-1:0] ages_q [LIMIT];

    rm_state_e state_q, state_d;

    function automatic logic [AGE_W-1:0] bump(input logic [AGE_W-1:0] a);
        return (a < AGE_MAX) ? a + 1'b1 : a;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig;
        end
    end

    assign toggled  = sig ^ sig_q;
    assign too_fast = toggled && (ages_q[LIMIT-1] < AGE_MAX);

    for (genvar j = 0; j < LIMIT; j++) begin : g_age
        if (j == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ages_q[j] <= AGE_MAX;
                end else if (toggled) begin
                    ages_q[j] <= AGE_W'(1);
                end else begin
                    ages_q[j] <= bump(ages_q[j]);
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ages_q[j] <= AGE_MAX;
                end else if (toggled) begin
                    ages_q[j] <= bump(ages_q[j-1]);
                end else begin
                    ages_q[j] <= bump(ages_q[j]);
                end
            end
        end
    end

    // next-state logic: a violation outranks a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RM_CLEAN: begin
                if (too_fast) begin
                    state_d = RM_TRIPPED;
                end
            end
            RM_TRIPPED: begin
                if (clr && !too_fast) begin
                    state_d = RM_CLEAN;
                end
            end
            default: state_d = RM_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RM_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RM_TRIPPED: flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/vidctl_pulse_filter.sv
module vidctl_pulse_filter
    import vcf_pkg::*;
#(
    parameter int MIN_W       = 3,
    parameter int WIN         = 130,
    parameter int LINE_LIMIT  = 2,
    parameter int FRAME_LIMIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_filt_en,
    input  logic       hs_in,
    input  logic       vs_in,
    input  logic       de_in,
    input  logic [2:0] viol_clr,
    output logic       hs_out,
    output logic       vs_out,
    output logic       de_out,
    output logic [2:0] viol_flag
);

    logic                filt_en_q;
    logic [NUM_CH-1:0]   raw_vec;
    logic [NUM_CH-1:0]   cond_vec;
    logic [NUM_CH-1:0]   flag_vec;

    // mode register, filter on after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_en_q <= 1'b1;
        end else if (cfg_wr) begin
            filt_en_q <= cfg_filt_en;
        end
    end

    always_comb begin
        raw_vec        = '0;
        raw_vec[CH_HS] = hs_in;
        raw_vec[CH_VS] = vs_in;
        raw_vec[CH_DE] = de_in;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam bit IS_FRAME = (c == CH_VS);

        vcf_deglitch #(
            .MIN_W    (MIN_W),
            .DEGLITCH (!IS_FRAME)
        ) u_dg (
            .clk     (clk),
            .rst_n   (rst_n),
            .filt_en (filt_en_q),
            .raw_in  (raw_vec[c]),
            .sig_out (cond_vec[c])
        );

        vcf_rate_mon #(
            .WIN   (WIN),
            .LIMIT (IS_FRAME ? FRAME_LIMIT : LINE_LIMIT)
        ) u_rm (
            .clk   (clk),
            .rst_n (rst_n),
            .sig   (cond_vec[c]),
            .clr   (viol_clr[c]),
            .flag  (flag_vec[c])
        );
    end

    assign hs_out    = cond_vec[CH_HS];
    assign vs_out    = cond_vec[CH_VS];
    assign de_out    = cond_vec[CH_DE];
    assign viol_flag = flag_vec;

endmodule

// File: rtl/vidctl_pulse_filter_chk.sv
module vidctl_pulse_filter_chk #(
    parameter int MIN_W = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       filt_q,
    input logic       hs_in,
    input logic       de_in,
    input logic       hs_out,
    input logic       vs_out,
    input logic       de_out,
    input logic [2:0] viol_flag,
    input logic [2:0] viol_clr
);

    logic [7:0]     since_rst_q;
    logic [MIN_W:0] hs_hist_q;
    logic [MIN_W:0] de_hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
            hs_hist_q   <= '0;
            de_hist_q   <= '0;
        end else begin
            if (since_rst_q != 8'hFF) begin
                since_rst_q <= since_rst_q + 8'd1;
            end
            hs_hist_q <= {hs_hist_q[MIN_W-1:0], hs_in};
            de_hist_q <= {de_hist_q[MIN_W-1:0], de_in};
        end
    end

    // R6: nothing leaves the block during the warm-up window
    assert_warmup_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q <= 8'(MIN_W)) |-> (!hs_out && !vs_out && !de_out));

    // R2: in filter mode a line sync change needs MIN_W agreeing raw samples
    assert_hs_consensus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_q) && (hs_out != $past(hs_out)))
        |-> (hs_hist_q[MIN_W:1] == {MIN_W{hs_out}}));

    // R3: same for the enable channel
    assert_de_consensus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_q) && (de_out != $past(de_out)))
        |-> (de_hist_q[MIN_W:1] == {MIN_W{de_out}}));

    // R7: a line flag rises only right after a line output toggle
    assert_hs_flag_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_flag[0]) |-> ($past(hs_out) != $past(hs_out, 2)));

    // R8: a frame flag rises only right after a frame output toggle
    assert_vs_flag_after_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_flag[1]) |-> ($past(vs_out) != $past(vs_out, 2)));

    // R9: a set flag without a clear stays set
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((viol_flag & ~viol_clr) != 3'b000)
        |=> ((($past(viol_flag) & ~$past(viol_clr)) & ~viol_flag) == 3'b000));

endmodule

bind vidctl_pulse_filter vidctl_pulse_filter_chk #(.MIN_W(MIN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .filt_q    (filt_en_q),
    .hs_in     (hs_in),
    .de_in     (de_in),
    .hs_out    (hs_out),
    .vs_out    (vs_out),
    .de_out    (de_out),
    .viol_flag (viol_flag),
    .viol_clr  (viol_clr)
);

// File: tb/vidctl_pulse_filter_tb_top.sv
module vidctl_pulse_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_filt_en = 1'b0;
    logic       hs_in = 1'b0;
    logic       vs_in = 1'b0;
    logic       de_in = 1'b0;
    logic [2:0] viol_clr = 3'b000;
    logic       hs_out;
    logic       vs_out;
    logic       de_out;
    logic [2:0] viol_flag;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    vidctl_pulse_filter dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_filt_en (cfg_filt_en),
        .hs_in       (hs_in),
        .vs_in       (vs_in),
        .de_in       (de_in),
        .viol_clr    (viol_clr),
        .hs_out      (hs_out),
        .vs_out      (vs_out),
        .de_out      (de_out),
        .viol_flag   (viol_flag)
    );

    // ---------------- behavioural reference model ----------------
    int m_cyc;
    bit m_filt;
    bit m_s0 [3];
    bit m_s1 [3];
    bit m_s2 [3];
    int m_n [3];
    bit m_started [3];
    bit m_out [3];
    bit m_flag [3];
    bit m_pend [3];
    int m_ntr [3];
    int m_tlast [3];
    int m_tprev [3];

    task automatic model_reset();
        m_cyc  = 0;
        m_filt = 1'b1;
        for (int c = 0; c < 3; c++) begin
            m_s0[c] = 0; m_s1[c] = 0; m_s2[c] = 0; m_n[c] = 0;
            m_started[c] = 0; m_out[c] = 0; m_flag[c] = 0; m_pend[c] = 0;
            m_ntr[c] = 0; m_tlast[c] = 0; m_tprev[c] = 0;
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int c = 0; c < 3; c++) begin
                bit raw;
                bit same;
                bit nout;
                bit nflag;
                int lim;
                int ref_t;
                raw   = (c == 0) ? hs_in : ((c == 1) ? vs_in : de_in);
                lim   = (c == 1) ? 1 : 2;
                nflag = m_pend[c] | (m_flag[c] & ~viol_clr[c]);
                m_pend[c] = 0;
                same  = (m_n[c] >= 3) && (m_s0[c] == m_s1[c]) && (m_s1[c] == m_s2[c]);
                nout  = m_out[c];
                if (!m_started[c]) begin
                    if (same) begin
                        m_started[c] = 1;
                        nout = m_s0[c];
                    end
                end else if (c != 1 && m_filt) begin
                    if (same) nout = m_s0[c];
                end else begin
                    nout = m_s2[c];
                end
                if (nout != m_out[c]) begin
                    ref_t = (lim == 1) ? m_tlast[c] : m_tprev[c];
                    if (m_ntr[c] >= lim && (m_cyc - ref_t) < 130) m_pend[c] = 1;
                    m_tprev[c] = m_tlast[c];
                    m_tlast[c] = m_cyc;
                    m_ntr[c]   = m_ntr[c] + 1;
                end
                m_out[c]  = nout;
                m_flag[c] = nflag;
                m_s2[c] = m_s1[c];
                m_s1[c] = m_s0[c];
                m_s0[c] = raw;
                if (m_n[c] < 3) m_n[c] = m_n[c] + 1;
            end
            if (cfg_wr) m_filt = cfg_filt_en;
            m_cyc = m_cyc + 1;
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp = n_cmp + 1;
            if (hs_out !== m_out[0] || vs_out !== m_out[1] || de_out !== m_out[2] ||
                viol_flag !== {m_flag[2], m_flag[1], m_flag[0]}) begin
                n_bad = n_bad + 1;
                $display("FAIL %s model compare @%0t: act hs/vs/de=%b%b%b flag=%b exp %b%b%b flag=%b%b%b",
                         phase, $time, hs_out, vs_out, de_out, viol_flag,
                         m_out[0], m_out[1], m_out[2], m_flag[2], m_flag[1], m_flag[0]);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input int c, input bit v);
        if (c == 0) hs_in = v;
        else if (c == 1) vs_in = v;
        else de_in = v;
    endtask

    function automatic bit outv(input int c);
        return (c == 0) ? hs_out : ((c == 1) ? vs_out : de_out);
    endfunction

    // high pulse of w clocks; reports first negedge with output high and high count
    task automatic pulse_meas(input int c, input int w, output int first, output int width);
        first = 0;
        width = 0;
        drive(c, 1'b1);
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            if (outv(c) && first == 0) first = i;
            if (outv(c)) width = width + 1;
            if (i == w) drive(c, 1'b0);
        end
    endtask

    task automatic set_mode(input bit en);
        cfg_filt_en = en;
        cfg_wr = 1'b1;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        viol_clr = m;
        tick(1);
        viol_clr = 3'b000;
        tick(1);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done  = 1'b1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act timeout exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int f;
        int w;
        tick(3);
        phase = "R1";
        chk({hs_out, vs_out, de_out} == 3'b000, "R1 outputs in reset", {hs_out, vs_out, de_out}, 0);
        chk(viol_flag == 3'b000, "R1 flags in reset", viol_flag, 0);
        rst_n = 1'b1;

        // warm-up: line sync toggles every clock, no stable run
        phase = "R6";
        for (int i = 0; i < 8; i++) begin
            hs_in = ~hs_in;
            tick(1);
            chk(hs_out == 1'b0, "R6 held low while unstable", hs_out, 0);
        end
        hs_in = 1'b0;
        tick(6);
        chk({hs_out, vs_out, de_out} == 3'b000, "R6 settled low", {hs_out, vs_out, de_out}, 0);
        chk(viol_flag == 3'b000, "R1 flags after reset", viol_flag, 0);
        tick(140);

        // filter on by default: short pulses dropped
        phase = "R2";
        pulse_meas(0, 1, f, w);
        chk(w == 0, "R2 hs 1-clock pulse dropped", w, 0);
        pulse_meas(0, 2, f, w);
        chk(w == 0, "R2 hs 2-clock pulse dropped", w, 0);
        pulse_meas(2, 2, f, w);
        chk(w == 0, "R2 de 2-clock pulse dropped", w, 0);

        // accepted pulses keep width, latency 3
        phase = "R3";
        pulse_meas(0, 3, f, w);
        chk(w == 3, "R3 hs width 3 kept", w, 3);
        chk(f == 4, "R3 hs latency", f, 4);
        pulse_meas(2, 7, f, w);
        chk(w == 7, "R3 de width 7 kept", w, 7);
        chk(f == 4, "R3 de latency", f, 4);
        tick(140);

        // bypass via mode register
        phase = "R10";
        set_mode(1'b0);
        phase = "R4";
        pulse_meas(0, 1, f, w);
        chk(w == 1, "R4 hs 1-clock pulse in bypass", w, 1);
        chk(f == 4, "R4 hs latency in bypass", f, 4);
        tick(140);
        pulse_meas(2, 2, f, w);
        chk(w == 2, "R4 de 2-clock pulse in bypass", w, 2);
        tick(140);

        // back to filter: 1-clock line pulse dropped again
        phase = "R10";
        set_mode(1'b1);
        pulse_meas(0, 1, f, w);
        chk(w == 0, "R10 filter re-enabled drops hs 1-clock", w, 0);

        // frame sync not deglitched; 1-clock frame pulse also violates R8
        phase = "R5";
        pulse_meas(1, 1, f, w);
        chk(w == 1, "R5 vs 1-clock pulse passes", w, 1);
        chk(f == 4, "R5 vs latency", f, 4);
        chk(viol_flag[1] == 1'b1, "R8 vs fast toggles flagged", viol_flag[1], 1);
        phase = "R9";
        tick(5);
        chk(viol_flag[1] == 1'b1, "R9 flag stays set", viol_flag[1], 1);
        clear(3'b010);
        chk(viol_flag[1] == 1'b0, "R9 clear drops vs flag", viol_flag[1], 0);
        tick(140);

        // frame spacing boundary
        phase = "R8";
        vs_in = 1'b1;
        tick(130);
        vs_in = 1'b0;
        tick(10);
        chk(viol_flag[1] == 1'b0, "R8 spacing 130 accepted", viol_flag[1], 0);
        tick(119);
        vs_in = 1'b1;
        tick(8);
        chk(viol_flag[1] == 1'b1, "R8 spacing 129 flagged", viol_flag[1], 1);
        tick(140);
        vs_in = 1'b0;
        tick(140);
        clear(3'b010);

        // line sync rate cap
        phase = "R7";
        hs_in = 1'b1; tick(65);
        hs_in = 1'b0; tick(65);
        hs_in = 1'b1; tick(10);
        chk(viol_flag[0] == 1'b0, "R7 third toggle at 130 accepted", viol_flag[0], 0);
        tick(150);
        hs_in = 1'b0; tick(4);
        hs_in = 1'b1; tick(4);
        hs_in = 1'b0; tick(8);
        chk(viol_flag[0] == 1'b1, "R7 three toggles in 8 clocks flagged", viol_flag[0], 1);
        chk(viol_flag[2] == 1'b0, "R7 enable flag untouched", viol_flag[2], 0);
        tick(140);
        clear(3'b001);

        // clear meets a new violation on the enable channel
        phase = "R9";
        de_in = 1'b1; tick(5);
        de_in = 1'b0; tick(5);
        de_in = 1'b1;       // sampled at edge s
        tick(4);            // now after edge s+3: output has just toggled
        viol_clr = 3'b100;  // seen at edge s+4 together with the new violation
        tick(1);
        viol_clr = 3'b000;
        tick(1);
        chk(viol_flag[2] == 1'b1, "R9 set wins over clear", viol_flag[2], 1);
        tick(3);
        clear(3'b100);
        chk(viol_flag[2] == 1'b0, "R9 later clear drops de flag", viol_flag[2], 0);
        de_in = 1'b0;
        tick(20);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule